// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block is a two-way set-associative cache placed between a 16-bit processor and a main memory of 4096 words. The processor raises a request with an address, a read/write flag and, for writes, a data word. It holds these until the cache pulses `cpu_ready` for one cycle. A request that hits completes in the same cycle. A request that misses stalls the processor while the cache exchanges whole blocks with memory.

Memory is reached through a word-wide port. The cache holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until memory answers with a one-cycle `mem_ack`. On a read, `mem_ack` also marks `mem_rdata` as valid. Every miss allocates a line, whether it is a read or a write. A victim line is copied back to memory only when it carries its modified flag. The victim way is taken from a one-bit usage history kept per set.

Top module: `wb_cache2w`

## Requirements
- R1: A read whose tag matches a valid line in either way of its set raises `cpu_ready` in the same cycle with the addressed word on `cpu_rdata`, and makes no memory access.
- R2: A read miss performs exactly four memory reads at block offsets 0, 1, 2, 3 of the requested block (address = tag in bits 11:8, set index in bits 7:2, offset in bits 1:0). It then returns the requested word with `cpu_ready`, with no memory write after the first refill read.
- R3: A write hit changes only the addressed word, raises `cpu_ready` in the same cycle and makes no memory access. The other three words of the line read back unchanged.
- R4: A write miss first refills the whole block (four reads, as in R2), then stores the new word into it. Later reads of the block return the new word for that address and the memory contents for the other three.
- R5: On a miss, a victim that was written while cached is copied back first, as four writes at offsets 0 to 3 of the address built from its stored tag and the set index, carrying the cached contents. A victim never written while cached causes no memory write.
- R6: When a set holds an invalid way, a miss fills that way and leaves the valid way in place.
- R7: When both ways are valid, a miss replaces the way accessed less recently in that set. A hit or a fill both count as an access.
- R8: While `mem_req` is high and not yet acknowledged, `mem_addr` and `mem_we` stay unchanged. `cpu_ready` is never high while `mem_req` is high.
- R9: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Word address: tag, set index, offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write back a word, 0 = refill read |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current word |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 12-bit address, 64 sets and four-word blocks. At this size the whole 4096-word address space can be swept three times within the cycle budget. An ascending read sweep, a descending write sweep and a second read sweep together produce clean evictions, dirty evictions, write hits and write misses in every set. A bench-side model of tags, valid and modified flags and usage bits predicts, for each access, the hit or miss, the beat counts and the write-back address. A short directed sequence on one set isolates the rules for choosing an invalid way and the least recently used way.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } wbc_state_e;

  // Victim choice: an empty way first, otherwise the way the usage bit names.
  function automatic logic pick_victim(input logic vld0, input logic vld1,
                                       input logic older_way);
    if (!vld0) return 1'b0;
    if (!vld1) return 1'b1;
    return older_way;
  endfunction

endpackage

// File: rtl/wbc_tags.sv
module wbc_tags #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           idx,
  output logic [1:0][TAG_W-1:0]      tag_o,
  output logic [1:0]                 vld_o,
  output logic [1:0]                 drt_o,
  output logic                       older_o,
  input  logic                       fill_en,
  input  logic                       fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       dirty_en,
  input  logic                       dirty_way,
  input  logic                       touch_en,
  input  logic                       touch_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] older_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_en && fill_way == 1'(w)) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= 1'b0;
      end else if (dirty_en && dirty_way == 1'(w)) begin
        drt_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[idx] <= fill_tag;
    end

    assign tag_o[w] = tag_q[idx];
    assign vld_o[w] = vld_q[idx];
    assign drt_o[w] = drt_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        older_q      <= '0;
    else if (touch_en) older_q[idx] <= ~touch_way;
  end

  assign older_o = older_q[idx];
endmodule

// File: rtl/wbc_data.sv
module wbc_data #(
  parameter int WORD_W = 16,
  parameter int LINE_W = 8
) (
  input  logic                   clk,
  input  logic [LINE_W-1:0]      rd_a,
  input  logic [LINE_W-1:0]      rd_b,
  output logic [1:0][WORD_W-1:0] rdat_a,
  output logic [1:0][WORD_W-1:0] rdat_b,
  input  logic                   we,
  input  logic                   wway,
  input  logic [LINE_W-1:0]      waddr,
  input  logic [WORD_W-1:0]      wdata
);
  localparam int DEPTH = 1 << LINE_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [WORD_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wway == 1'(w)) word_q[waddr] <= wdata;
    end

    assign rdat_a[w] = word_q[rd_a];
    assign rdat_b[w] = word_q[rd_b];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             lookup_hit,
  input  logic             victim_way,
  input  logic             victim_dirty,
  input  logic             mem_ack,
  output wbc_state_e       state_o,
  output logic [OFF_W-1:0] beat_o,
  output logic             way_o,
  output logic             miss_start,
  output logic             fill_beat,
  output logic             fill_last
);
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  wbc_state_e       state_q;
  logic [OFF_W-1:0] beat_q;
  logic             way_q;

  assign miss_start = (state_q == ST_IDLE) && cpu_req && !lookup_hit;
  assign fill_beat  = (state_q == ST_FILL) && mem_ack;
  assign fill_last  = fill_beat && (beat_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      way_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (miss_start) begin
            way_q   <= victim_way;
            beat_q  <= '0;
            state_q <= victim_dirty ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign way_o   = way_q;
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w
  import wbc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = IDX_W + OFF_W;

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [ADDR_W-1:0] f_join(input logic [TAG_W-1:0] t,
                                              input logic [IDX_W-1:0] i,
                                              input logic [OFF_W-1:0] o);
    return {t, i, o};
  endfunction

  logic [TAG_W-1:0]        req_tag;
  logic [IDX_W-1:0]        req_idx;
  logic [OFF_W-1:0]        req_off;
  logic [1:0][TAG_W-1:0]   way_tag;
  logic [1:0]              way_vld, way_drt, way_hit;
  logic                    set_older;
  logic                    hit_way, lookup_hit;
  logic                    victim_way, victim_dirty;
  wbc_state_e              state;
  logic [OFF_W-1:0]        beat;
  logic                    fill_way;
  logic                    miss_start, fill_beat, fill_last;
  logic [1:0][WORD_W-1:0]  rdat_a, rdat_b;
  logic                    dwe, dway;
  logic [LINE_W-1:0]       dwaddr;
  logic [WORD_W-1:0]       dwdata;

  assign req_tag = f_tag(cpu_addr);
  assign req_idx = f_idx(cpu_addr);
  assign req_off = f_off(cpu_addr);

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = way_vld[w] && (way_tag[w] == req_tag);
  end

  assign hit_way      = way_hit[1];
  assign lookup_hit   = (state == ST_IDLE) && cpu_req && (|way_hit);
  assign victim_way   = pick_victim(way_vld[0], way_vld[1], set_older);
  assign victim_dirty = way_vld[victim_way] && way_drt[victim_way];

  wbc_tags #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (req_idx),
    .tag_o     (way_tag),
    .vld_o     (way_vld),
    .drt_o     (way_drt),
    .older_o   (set_older),
    .fill_en   (fill_last),
    .fill_way  (fill_way),
    .fill_tag  (req_tag),
    .dirty_en  (lookup_hit && cpu_we),
    .dirty_way (hit_way),
    .touch_en  (lookup_hit || fill_last),
    .touch_way (fill_last ? fill_way : hit_way)
  );

  assign dwe    = (lookup_hit && cpu_we) || fill_beat;
  assign dway   = fill_beat ? fill_way : hit_way;
  assign dwaddr = fill_beat ? {req_idx, beat} : {req_idx, req_off};
  assign dwdata = fill_beat ? mem_rdata : cpu_wdata;

  wbc_data #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_data (
    .clk    (clk),
    .rd_a   ({req_idx, req_off}),
    .rd_b   ({req_idx, beat}),
    .rdat_a (rdat_a),
    .rdat_b (rdat_b),
    .we     (dwe),
    .wway   (dway),
    .waddr  (dwaddr),
    .wdata  (dwdata)
  );

  wbc_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .lookup_hit   (lookup_hit),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state_o      (state),
    .beat_o       (beat),
    .way_o        (fill_way),
    .miss_start   (miss_start),
    .fill_beat    (fill_beat),
    .fill_last    (fill_last)
  );

  assign cpu_ready = lookup_hit;
  assign cpu_rdata = rdat_a[hit_way];
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = f_join(mem_we ? way_tag[fill_way] : req_tag, req_idx, beat);
  assign mem_wdata = rdat_b[fill_way];
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              miss_start,
  input logic              victim_dirty
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  logic last_beat;
  assign last_beat = mem_req && mem_ack && (mem_addr[OFF_W-1:0] == LAST_OFF);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8

  AST_NO_READY_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready); // R8

  AST_FILL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we && !last_beat
    |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)); // R2

  AST_FILL_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && !mem_we && cpu_req |=> cpu_ready); // R2

  AST_WB_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we && !last_beat
    |=> mem_req && mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)); // R5

  AST_WB_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && mem_we |=> mem_req && !mem_we && mem_addr[OFF_W-1:0] == '0); // R5

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start && !victim_dirty |=> mem_req && !mem_we); // R5

  AST_DIRTY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start && victim_dirty |=> mem_req && mem_we && mem_addr[OFF_W-1:0] == '0); // R5
endmodule

bind wb_cache2w wbc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_ready    (cpu_ready),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .miss_start   (miss_start),
  .victim_dirty (victim_dirty)
);

// File: tb/wb_cache2w_bench.sv
module wb_cache2w_bench;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          cpu_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_ack;

  always #4 clk = ~clk;

  wb_cache2w u_wb_cache2w (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] mem     [4096];
  logic [DW-1:0] ref_mem [4096];
  int            m_tag [2][64];
  bit            m_vld [2][64];
  bit            m_drt [2][64];
  bit            m_old [64];

  int            rd_beats = 0, wr_beats = 0;
  int            hs_bad = 0, order_bad = 0;
  bit            saw_fill = 1'b0;
  logic [1:0]    next_off = 2'd0;
  logic [AW-1:0] last_fill_base = '0, last_wb_base = '0;
  bit            hold_pend = 1'b0;
  logic [AW-1:0] hold_addr = '0;
  logic          hold_we = 1'b0;

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 7) ^ 16'h5A3C;
  endfunction

  // Memory model: acknowledges each word one cycle after the request appears.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      hold_pend <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr];
      if (mem_req && mem_ack) begin
        if (mem_addr[1:0] != next_off) order_bad <= order_bad + 1;
        next_off <= mem_addr[1:0] + 2'd1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wr_beats <= wr_beats + 1;
          if (mem_addr[1:0] == 2'd0) last_wb_base <= mem_addr;
          if (saw_fill) order_bad <= order_bad + 1;
        end else begin
          rd_beats <= rd_beats + 1;
          saw_fill <= 1'b1;
          if (mem_addr[1:0] == 2'd0) last_fill_base <= mem_addr;
        end
      end
      if (cpu_ready) saw_fill <= 1'b0;
      if (hold_pend && (!mem_req || mem_addr != hold_addr || mem_we != hold_we))
        hs_bad <= hs_bad + 1;
      if (mem_req && cpu_ready) hs_bad <= hs_bad + 1;
      hold_pend <= mem_req && !mem_ack;
      hold_addr <= mem_addr;
      hold_we   <= mem_we;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output bit was_hit);
    int            t   = int'(a[11:8]);
    int            i   = int'(a[7:2]);
    int            way;
    int            exp_rd, exp_wr;
    int            rd0, wr0;
    logic [AW-1:0] wb_base = '0;
    logic [DW-1:0] got;
    string         tagr;

    was_hit = 1'b0;
    exp_rd  = 0;
    exp_wr  = 0;
    if (m_vld[0][i] && m_tag[0][i] == t) begin was_hit = 1'b1; way = 0; end
    else if (m_vld[1][i] && m_tag[1][i] == t) begin was_hit = 1'b1; way = 1; end
    else begin
      way = !m_vld[0][i] ? 0 : (!m_vld[1][i] ? 1 : int'(m_old[i]));
      if (m_vld[way][i] && m_drt[way][i]) begin
        exp_wr  = 4;
        wb_base = {4'(m_tag[way][i]), 6'(i), 2'b00};
      end
      exp_rd = 4;
      m_vld[way][i] = 1'b1;
      m_tag[way][i] = t;
      m_drt[way][i] = 1'b0;
    end
    m_old[i] = (way == 0);
    if (we) m_drt[way][i] = 1'b1;
    tagr = was_hit ? (we ? "R3" : "R1") : (we ? "R4" : "R2");

    rd0 = rd_beats;
    wr0 = wr_beats;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      #1;
    end
    got = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;

    chk(rd_beats - rd0 == exp_rd, tagr, "refill reads", rd_beats - rd0, exp_rd);
    chk(wr_beats - wr0 == exp_wr, "R5", "write-back writes", wr_beats - wr0, exp_wr);
    if (exp_wr != 0) begin
      chk(last_wb_base == wb_base, "R5", "write-back base", int'(last_wb_base), int'(wb_base));
      for (int k = 0; k < 4; k++)
        chk(mem[wb_base + AW'(k)] == ref_mem[wb_base + AW'(k)], "R5", "written-back word",
            int'(mem[wb_base + AW'(k)]), int'(ref_mem[wb_base + AW'(k)]));
    end
    if (!was_hit)
      chk(last_fill_base == {a[11:2], 2'b00}, tagr, "refill base",
          int'(last_fill_base), int'({a[11:2], 2'b00}));
    if (!we) chk(got == ref_mem[a], tagr, "read data", int'(got), int'(ref_mem[a]));
    else     ref_mem[a] = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired before the run finished");
    finish_run();
  end

  initial begin
    bit h;
    logic [AW-1:0] pa, pb, pc;
    for (int a = 0; a < 4096; a++) begin
      mem[a]     = init_word(a);
      ref_mem[a] = init_word(a);
    end
    for (int s = 0; s < 64; s++) begin
      m_old[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[w][s] = 1'b0; m_drt[w][s] = 1'b0; m_tag[w][s] = 0;
      end
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R9", "cpu_ready in reset", int'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R9", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;

    // Directed replacement sequence on set 5: tags 1, 2, 3.
    pa = {4'd1, 6'd5, 2'd1};
    pb = {4'd2, 6'd5, 2'd3};
    pc = {4'd3, 6'd5, 2'd0};
    access(0, pa, '0, h); chk(!h, "R9", "first access after reset misses", int'(h), 0);
    access(0, pb, '0, h); chk(!h, "R6", "second tag misses", int'(h), 0);
    access(0, pa, '0, h); chk(h, "R6", "first tag kept in other way", int'(h), 1);
    access(0, pb, '0, h); chk(h, "R6", "second tag resident", int'(h), 1);
    access(0, pa, '0, h); chk(h, "R7", "touch first tag", int'(h), 1);
    access(0, pc, '0, h); chk(!h, "R7", "third tag misses", int'(h), 0);
    access(0, pa, '0, h); chk(h, "R7", "recently used tag survives", int'(h), 1);
    access(0, pb, '0, h); chk(!h, "R7", "older tag was replaced", int'(h), 0);

    // Write hit and write miss, then read the neighbours back.
    access(1, pa, 16'hBEEF, h); chk(h, "R3", "write hit", int'(h), 1);
    for (int k = 0; k < 4; k++) access(0, {pa[11:2], 2'(k)}, '0, h);
    access(1, {4'd9, 6'd9, 2'd2}, 16'hC0DE, h); chk(!h, "R4", "write miss", int'(h), 0);
    for (int k = 0; k < 4; k++) access(0, {4'd9, 6'd9, 2'(k)}, '0, h);

    // Sweeps over the whole address space.
    for (int a = 0; a < 4096; a++) access(0, AW'(a), '0, h);
    for (int a = 4095; a >= 0; a--) access(1, AW'(a), ~init_word(a) ^ DW'(a), h);
    for (int a = 0; a < 4096; a++) access(0, AW'(a), '0, h);

    @(negedge clk);
    chk(hs_bad == 0, "R8", "handshake hold violations", hs_bad, 0);
    chk(order_bad == 0, "R2", "beat order violations", order_bad, 0);
    finish_run();
  end
endmodule